// File: doc/BRIEF.md
# Iterative Multiply and Multiply-Accumulate Unit

This block is a multiplier execution unit for a 32-bit integer core. One iterative shift-add datapath serves six operations, selected by a 3-bit operation code. The operations cover a truncated 32-bit product, a 32-bit product plus an addend, and unsigned or signed 64-bit products. Each of the 64-bit products comes with or without a 64-bit accumulate. The core presents two operands and an accumulate value, then pulses `start`. The unit raises `busy` for a fixed number of cycles and returns the result with a one-cycle `done` pulse.

When `setFlags` is set at issue, the negative and zero condition flags are updated from the finished result. Otherwise they keep their old values. Codes 010 and 011 are reserved. They only produce a one-cycle `illegalOp` pulse.

Top module: `mac_unit`

## Requirements
- R1: Code 000 returns bits [31:0] of opA×opB in `result[31:0]`, with `result[63:32]` zero.
- R2: Code 001 returns (opA×opB + accIn[31:0]) modulo 2^32 in `result[31:0]`, with the upper half zero.
- R3: Code 100 returns the full 64-bit unsigned product of opA and opB.
- R4: Code 101 returns (unsigned opA×opB + accIn) modulo 2^64.
- R5: Code 110 returns the 64-bit two's-complement product of signed opA and opB.
- R6: Code 111 returns (signed opA×opB + accIn) modulo 2^64.
- R7: With `setFlags`=1 at issue, `flagN` takes result bit 31 (codes 00x) or bit 63 (codes 1xx). `flagZ` is set when the whole 32-bit or 64-bit result is zero. With `setFlags`=0, both flags keep their values.
- R8: A start with code 010 or 011 while idle gives `illegalOp`=1 for exactly the next cycle. It does not raise `busy` or `done` and leaves `result` and the flags unchanged.
- R9: After a legal start is taken at a clock edge, `busy` is 1 for the next WIDTH+1 cycles. `done` is then 1 for one cycle while `busy` is 0, and `result` and the flags are updated at that same edge.
- R10: A start while `busy` is 1 is ignored. The running operation completes with its own operands, on its own schedule.
- R11: After reset, `result`, `flagN`, `flagZ`, `done`, `busy` and `illegalOp` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe |
| opSel | input | 3 | Operation code |
| setFlags | input | 1 | Update the N and Z flags on completion |
| opA | input | 32 | First multiply operand |
| opB | input | 32 | Second multiply operand |
| accIn | input | 64 | Accumulate value (low half used by code 001) |
| result | output | 64 | Last result |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| illegalOp | output | 1 | Reserved code pulse |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |

## Verification
Small operands confirm the basic product. Operand pairs whose 32-bit truncation is zero separate the truncated forms from the long forms and exercise the zero flag. All-ones operands expose wrong signedness handling, because the unsigned and signed long products of the same bits differ in their upper half. The most negative value squared and mixed-sign pairs check the sign correction. Addends chosen to wrap past 2^32 and 2^64 confirm the modulo accumulate. Stimulus issued while busy, flag-inhibited operations and reserved codes show that these inputs leave the result, the flags and the schedule untouched.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } macCtl_t;

  function automatic logic opLegal(input logic [2:0] op);
    return op[2] | ~op[1];
  endfunction

  function automatic logic opLong(input logic [2:0] op);
    return op[2];
  endfunction

  function automatic logic opSigned(input logic [2:0] op);
    return op[2] & op[1];
  endfunction

  function automatic logic opAccum(input logic [2:0] op);
    return op[0];
  endfunction
endpackage

// File: rtl/mac_control.sv
module mac_control import mac_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opSel,
  output macCtl_t    ctl,
  output logic       busy,
  output logic       done,
  output logic       illegalOp
);
  localparam int CW = $clog2(WIDTH + 1);

  typedef enum logic [1:0] {IDLE, RUN, FIN} state_t;
  state_t state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    ctl.load   = (state == IDLE) && start && opLegal(opSel);
    ctl.step   = (state == RUN);
    ctl.finish = (state == FIN);
  end

  assign busy = (state != IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= IDLE;
      stepCnt   <= '0;
      done      <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      done      <= ctl.finish;
      illegalOp <= (state == IDLE) && start && !opLegal(opSel);
      case (state)
        IDLE: if (ctl.load) begin
          state   <= RUN;
          stepCnt <= '0;
        end
        RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CW'(WIDTH - 1)) state <= FIN;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath import mac_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  macCtl_t            ctl,
  input  logic [2:0]         opSel,
  input  logic               setFlags,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [2*WIDTH-1:0] accIn,
  output logic [2*WIDTH-1:0] result,
  output logic               flagN,
  output logic               flagZ
);
  localparam int DW = 2 * WIDTH;

  logic [2:0]       opReg;
  logic             sfReg;
  logic             negRes;
  logic [DW-1:0]    accReg;
  logic [DW-1:0]    mcand;
  logic [WIDTH-1:0] mplier;
  logic [DW-1:0]    prod;

  logic [WIDTH-1:0] magA, magB;
  logic             negA, negB;
  logic [DW-1:0]    signedProd, addend, fullSum, finalRes;
  logic             nextN, nextZ;

  always_comb begin
    negA = opSigned(opSel) & opA[WIDTH-1];
    negB = opSigned(opSel) & opB[WIDTH-1];
    magA = negA ? (~opA + 1'b1) : opA;
    magB = negB ? (~opB + 1'b1) : opB;
  end

  always_comb begin
    signedProd = negRes ? (~prod + 1'b1) : prod;
    addend     = opAccum(opReg) ? accReg : '0;
    fullSum    = signedProd + addend;
    if (opLong(opReg)) begin
      finalRes = fullSum;
      nextN    = fullSum[DW-1];
    end else begin
      finalRes = {{WIDTH{1'b0}}, fullSum[WIDTH-1:0]};
      nextN    = fullSum[WIDTH-1];
    end
    nextZ = (finalRes == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg  <= '0;
      sfReg  <= 1'b0;
      negRes <= 1'b0;
      accReg <= '0;
      mcand  <= '0;
      mplier <= '0;
      prod   <= '0;
      result <= '0;
      flagN  <= 1'b0;
      flagZ  <= 1'b0;
    end else begin
      if (ctl.load) begin
        opReg  <= opSel;
        sfReg  <= setFlags;
        negRes <= negA ^ negB;
        accReg <= accIn;
        mcand  <= {{WIDTH{1'b0}}, magA};
        mplier <= magB;
        prod   <= '0;
      end
      if (ctl.step) begin
        if (mplier[0]) prod <= prod + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
      end
      if (ctl.finish) begin
        result <= finalRes;
        if (sfReg) begin
          flagN <= nextN;
          flagZ <= nextZ;
        end
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit import mac_pkg::*; #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [2:0]         opSel,
  input  logic               setFlags,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [2*WIDTH-1:0] accIn,
  output logic [2*WIDTH-1:0] result,
  output logic               done,
  output logic               busy,
  output logic               illegalOp,
  output logic               flagN,
  output logic               flagZ
);
  macCtl_t ctl;

  mac_control #(.WIDTH(WIDTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .ctl(ctl), .busy(busy), .done(done), .illegalOp(illegalOp)
  );

  mac_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opSel(opSel), .setFlags(setFlags),
    .opA(opA), .opB(opB), .accIn(accIn),
    .result(result), .flagN(flagN), .flagZ(flagZ)
  );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [2:0]         opSel,
  input logic [2*WIDTH-1:0] result,
  input logic               done,
  input logic               busy,
  input logic               illegalOp,
  input logic               flagN,
  input logic               flagZ
);
  // R9: completion is a single pulse that ends a busy period
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: result only moves at completion
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));
  // R7: flags only move at completion
  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({flagN, flagZ}));
  // R8: reserved code start from idle gives the pulse and no busy
  p_illegal_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && (opSel[2:1] == 2'b01)) |=> (illegalOp && !busy));
  p_illegal_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |=> !illegalOp);
  // R10: busy cannot be cut short by another start
  p_busy_keeps_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !done) |=> (busy || done));
endmodule

bind mac_unit mac_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .result(result),
  .done(done), .busy(busy), .illegalOp(illegalOp), .flagN(flagN), .flagZ(flagZ)
);

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int LAT = W + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] opSel = '0;
  logic setFlags = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic [2*W-1:0] accIn = '0;
  logic [2*W-1:0] result;
  logic done, busy, illegalOp, flagN, flagZ;

  int total = 0;
  int bad = 0;
  logic mN = 1'b0, mZ = 1'b0;
  logic [63:0] mRes = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .setFlags(setFlags),
    .opA(opA), .opB(opB), .accIn(accIn), .result(result), .done(done),
    .busy(busy), .illegalOp(illegalOp), .flagN(flagN), .flagZ(flagZ)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] refModel(input logic [2:0] op, input logic [31:0] a,
                                           input logic [31:0] b, input logic [63:0] acc);
    logic [63:0] pu, ps, r;
    pu = {32'b0, a} * {32'b0, b};
    ps = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    case (op)
      3'b000: r = {32'b0, pu[31:0]};
      3'b001: r = {32'b0, pu[31:0] + acc[31:0]};
      3'b100: r = pu;
      3'b101: r = pu + acc;
      3'b110: r = ps;
      default: r = ps + acc;
    endcase
    return r;
  endfunction

  // Issue one legal op; optionally poke a second start while busy (R10)
  task automatic runOp(input string req, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [63:0] acc, input logic sf,
                       input bit poke);
    logic [63:0] exp;
    int timingBad = 0;
    exp = refModel(op, a, b, acc);
    @(negedge clk);
    start = 1'b1; opSel = op; opA = a; opB = b; accIn = acc; setFlags = sf;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= LAT; n++) begin
      if (busy !== 1'b1 || done !== 1'b0 || result !== mRes) timingBad++;
      if (poke && n == 5) begin
        start = 1'b1; opSel = 3'b100; opA = 32'h1234_5678; opB = 32'h9abc_def0;
        accIn = '1; setFlags = ~sf;
      end
      if (poke && n == 6) start = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    if (busy !== 1'b0 || done !== 1'b1) timingBad++;
    check("R9 schedule", 64'(timingBad), 64'd0);
    mRes = exp;
    if (sf) begin
      mN = op[2] ? exp[63] : exp[31];
      mZ = op[2] ? (exp == 0) : (exp[31:0] == 0);
    end
    check(req, result, exp);
    check("R7 flags", {62'b0, flagN, flagZ}, {62'b0, mN, mZ});
    @(negedge clk);
    check("R9 done single", {63'b0, done}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset result", result, 64'd0);
    check("R11 reset status", {59'b0, done, busy, illegalOp, flagN, flagZ}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    runOp("R1 mul small", 3'b000, 32'd3, 32'd5, 64'hffff_ffff_ffff_ffff, 1'b1, 0);
    runOp("R1 mul trunc zero", 3'b000, 32'h0001_0000, 32'h0001_0000, '0, 1'b1, 0);
    runOp("R2 mla wrap", 3'b001, 32'hffff_ffff, 32'd1, 64'hdead_0000_0000_0001, 1'b1, 0);
    runOp("R2 mla neg", 3'b001, 32'h4000_0000, 32'd2, 64'd7, 1'b1, 0);
    runOp("R3 umull ones", 3'b100, 32'hffff_ffff, 32'hffff_ffff, 64'd99, 1'b1, 0);
    runOp("R3 umull hi only", 3'b100, 32'h0001_0000, 32'h0001_0000, '0, 1'b1, 0);
    runOp("R4 umlal wrap", 3'b101, 32'd1, 32'd1, 64'hffff_ffff_ffff_ffff, 1'b1, 0);
    runOp("R4 umlal big", 3'b101, 32'h8000_0001, 32'h0000_0003, 64'h0123_4567_89ab_cdef, 1'b1, 0);
    runOp("R5 smull ones", 3'b110, 32'hffff_ffff, 32'hffff_ffff, '0, 1'b1, 0);
    runOp("R5 smull mixed", 3'b110, 32'hffff_fffe, 32'd7, '0, 1'b1, 0);
    runOp("R5 smull minneg", 3'b110, 32'h8000_0000, 32'h8000_0000, '0, 1'b1, 0);
    runOp("R6 smlal cancel", 3'b111, 32'hffff_ffff, 32'd5, 64'd5, 1'b1, 0);
    runOp("R6 smlal neg", 3'b111, 32'd3, 32'hffff_fff0, 64'd10, 1'b1, 0);
    runOp("R7 no flag update", 3'b110, 32'hffff_ffff, 32'd1, '0, 1'b0, 0);
    runOp("R10 start while busy", 3'b000, 32'd6, 32'd7, '0, 1'b1, 1);

    // R8: reserved codes
    for (int k = 2; k <= 3; k++) begin
      @(negedge clk);
      start = 1'b1; opSel = 3'(k); opA = 32'd9; opB = 32'd9; accIn = '0; setFlags = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check("R8 illegal pulse", {62'b0, illegalOp, busy}, 64'd2);
      @(posedge clk);
      @(negedge clk);
      check("R8 illegal ends", {61'b0, illegalOp, busy, done}, 64'd0);
      check("R8 result kept", result, mRes);
      check("R8 flags kept", {62'b0, flagN, flagZ}, {62'b0, mN, mZ});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule